// File: doc/BRIEF.md
# Keyed XOR Encrypt/Verify Sequencer

This block is a secure-side sequencer that holds a fixed ten-byte secret key as a parameter and runs one of two commands over a ten-byte window of an external byte-wide memory. The window starts at a pointer supplied with the command. An **encrypt** command replaces each byte of the window with that byte XORed with the matching key byte. It then reports how many clock cycles the whole run kept the block busy. A **verify** command folds the per-byte XOR differences into an OR accumulator and reports the accumulator, where zero means the window holds the key. A verify that matches then writes a fixed secret payload into memory just past the window, unless that payload would run off the end of memory. In that case it raises an error flag and writes nothing.

Every XOR goes through an external ALU port with a request/acknowledge handshake. The ALU may acknowledge in the cycle of the request (a cached result) or one cycle later, so the encrypt duration depends on the data. The sequencer's working registers (pointer, index, data, accumulator) are private and are never shared with the caller.

The controller is a state machine with these states:
- **IDLE** goes to READ when a command is accepted.
- **READ** latches the memory byte and goes to XOR.
- **XOR** holds the ALU request until it is acknowledged. It then goes to WBACK for encrypt, to READ for a verify byte that is not the last, or to CHECK after the last verify byte.
- **WBACK** writes back the encrypted byte and goes to READ, or to IDLE after the last byte.
- **CHECK** goes to PAYLD when the accumulator is zero and the payload fits. Otherwise it goes to IDLE.
- **PAYLD** writes payload bytes and goes to IDLE after the last one.

Top module: `xks_seq`

## Requirements
- R1: After reset `busy`, `done`, `result` and `pay_err` are 0 and no memory write is issued.
- R2: Encrypt (`cmd_verify`=0) sets memory byte ptr+k to its old value XOR key byte k for k = 0..9, where key byte k is `KEY[8k+7:8k]`. No other byte is written.
- R3: Encrypt reports in `result` the number of cycles `busy` was high: 3 per byte whose ALU acknowledge comes in the request cycle and 4 per byte whose acknowledge comes one cycle later (30 to 40 for ten bytes).
- R4: Verify (`cmd_verify`=1) reports in `result` the OR over k of (memory byte ptr+k XOR key byte k). When that is nonzero it writes no memory and leaves `pay_err` at 0.
- R5: When the verify result is 0 and ptr+10+PAY_LEN <= 4096, payload byte j (`PAYLOAD[8j+7:8j]`) is written to address ptr+10+j for j = 0..PAY_LEN-1.
- R6: When the verify result is 0 but ptr+10+PAY_LEN > 4096, `pay_err` is 1 at completion, `result` is 0 and no payload byte is written.
- R7: `busy` rises in the cycle after a command is accepted and stays high until completion. `done` is a one-cycle pulse in the first cycle with `busy` low. `result` and `pay_err` are valid from that cycle on.
- R8: A `cmd_valid` seen while `busy` is high is ignored. It produces no second completion and no memory write.
- R9: Window addresses wrap modulo 4096, so a window starting at 0xFFB covers 0xFFB..0xFFF and then 0x000..0x004.
- R10: Each XOR is requested on `alu_req` with the memory byte on `alu_a` and the key byte on `alu_b`. Both operands are held stable until `alu_ack`, and `alu_y` is taken as the XOR result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted only when idle |
| cmd_verify | input | 1 | 0 = encrypt, 1 = verify |
| cmd_ptr | input | 12 | Start address of the ten-byte window |
| busy | output | 1 | High while a command runs |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | Encrypt cycle count, or verify OR accumulator |
| pay_err | output | 1 | Payload write refused (out of memory) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 12 | Memory address for read and write |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data (combinational from `mem_addr`) |
| alu_req | output | 1 | ALU XOR request |
| alu_a | output | 8 | ALU operand: memory byte |
| alu_b | output | 8 | ALU operand: key byte |
| alu_ack | input | 1 | ALU result valid |
| alu_y | input | 8 | ALU result |

## Verification
The hardest situation to reach is a verify that matches, since it needs the exact secret sitting in memory at the pointer. The payload bound check also needs the match placed at the last fitting address and one past it. The bench plants the key bytes directly into its memory model at 0x400, at 0xFF2 (exact fit) and at 0xFF3 (one byte over). It drives a per-request hit mask on its ALU model so that encrypt durations of 30, 35 and 40 cycles can each be predicted. A verify command aimed at a planted key is fired while an encrypt is running, to show that it is dropped.

// File: rtl/xks_pkg.sv
package xks_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_XOR,
        S_WBACK,
        S_CHECK,
        S_PAYLD
    } xks_state_e;

endpackage

// File: rtl/xks_byte_pick.sv
module xks_byte_pick #(
    parameter int                  COUNT = 10,
    parameter int                  SW    = 4,
    parameter logic [8*COUNT-1:0]  VEC   = '0
) (
    input  logic [SW-1:0] sel,
    output logic [7:0]    byte_o
);

    logic [7:0] lanes [COUNT];

    for (genvar g = 0; g < COUNT; g++) begin : g_lane
        assign lanes[g] = VEC[8*g +: 8];
    end

    always_comb begin
        byte_o = '0;
        for (int i = 0; i < COUNT; i++) begin
            if (sel == SW'(i)) byte_o = lanes[i];
        end
    end

endmodule

// File: rtl/xks_tick_ctr.sv
module xks_tick_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (en)  count <= count + 1'b1;
    end

endmodule

// File: rtl/xks_seq.sv
module xks_seq
    import xks_pkg::*;
#(
    parameter int                   N_BYTES   = 10,
    parameter int                   MEM_BYTES = 4096,
    parameter int                   PAY_LEN   = 4,
    parameter int                   RES_W     = 8,
    parameter logic [8*N_BYTES-1:0] KEY       = 80'h9C5E21B704F368AD12E5,
    parameter logic [8*PAY_LEN-1:0] PAYLOAD   = 32'h7A19C45B
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    input  logic                          cmd_verify,
    input  logic [$clog2(MEM_BYTES)-1:0]  cmd_ptr,
    output logic                          busy,
    output logic                          done,
    output logic [RES_W-1:0]              result,
    output logic                          pay_err,
    output logic                          mem_we,
    output logic [$clog2(MEM_BYTES)-1:0]  mem_addr,
    output logic [7:0]                    mem_wdata,
    input  logic [7:0]                    mem_rdata,
    output logic                          alu_req,
    output logic [7:0]                    alu_a,
    output logic [7:0]                    alu_b,
    input  logic                          alu_ack,
    input  logic [7:0]                    alu_y
);

    localparam int AW = $clog2(MEM_BYTES);
    localparam int IW = $clog2(N_BYTES);
    localparam int PW = (PAY_LEN > 1) ? $clog2(PAY_LEN) : 1;
    localparam int BW = AW + 2;

    xks_state_e        state_q, state_d;
    logic              op_q;
    logic [AW-1:0]     base_q;
    logic [IW-1:0]     idx_q;
    logic [PW-1:0]     pidx_q;
    logic [7:0]        data_q, y_q, acc_q;
    logic [RES_W-1:0]  result_q;
    logic              done_q, err_q;
    logic [RES_W-1:0]  ticks;
    logic [7:0]        key_byte, pay_byte;
    logic              last_byte, last_pay, fits, accept;

    assign last_byte = (idx_q == IW'(N_BYTES - 1));
    assign last_pay  = (pidx_q == PW'(PAY_LEN - 1));
    assign fits      = ({2'b00, base_q} + BW'(N_BYTES) + BW'(PAY_LEN)) <= BW'(MEM_BYTES);
    assign accept    = (state_q == S_IDLE) && cmd_valid;

    xks_byte_pick #(.COUNT(N_BYTES), .SW(IW), .VEC(KEY)) u_key (
        .sel    (idx_q),
        .byte_o (key_byte)
    );

    xks_byte_pick #(.COUNT(PAY_LEN), .SW(PW), .VEC(PAYLOAD)) u_pay (
        .sel    (pidx_q),
        .byte_o (pay_byte)
    );

    xks_tick_ctr #(.W(RES_W)) u_ticks (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .en    (state_q != S_IDLE),
        .count (ticks)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        mem_we    = 1'b0;
        mem_addr  = base_q + AW'(idx_q);
        mem_wdata = y_q;
        alu_req   = 1'b0;
        alu_a     = data_q;
        alu_b     = key_byte;
        unique case (state_q)
            S_IDLE:  if (cmd_valid) state_d = S_READ;
            S_READ:  state_d = S_XOR;
            S_XOR: begin
                alu_req = 1'b1;
                if (alu_ack) begin
                    if (!op_q)          state_d = S_WBACK;
                    else if (last_byte) state_d = S_CHECK;
                    else                state_d = S_READ;
                end
            end
            S_WBACK: begin
                mem_we  = 1'b1;
                state_d = last_byte ? S_IDLE : S_READ;
            end
            S_CHECK: state_d = (acc_q == 8'h00 && fits) ? S_PAYLD : S_IDLE;
            S_PAYLD: begin
                mem_we    = 1'b1;
                mem_addr  = base_q + AW'(N_BYTES) + AW'(pidx_q);
                mem_wdata = pay_byte;
                if (last_pay) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // private working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= 1'b0;
            base_q   <= '0;
            idx_q    <= '0;
            pidx_q   <= '0;
            data_q   <= '0;
            y_q      <= '0;
            acc_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                op_q   <= cmd_verify;
                base_q <= cmd_ptr;
                idx_q  <= '0;
                pidx_q <= '0;
                acc_q  <= '0;
                err_q  <= 1'b0;
            end
            if (state_q == S_READ) data_q <= mem_rdata;
            if (state_q == S_XOR && alu_ack) begin
                y_q <= alu_y;
                if (op_q) begin
                    acc_q <= acc_q | alu_y;
                    if (!last_byte) idx_q <= idx_q + 1'b1;
                end
            end
            if (state_q == S_WBACK) begin
                if (last_byte) begin
                    done_q   <= 1'b1;
                    result_q <= ticks + 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
            if (state_q == S_CHECK) begin
                if (acc_q != 8'h00) begin
                    done_q   <= 1'b1;
                    result_q <= RES_W'(acc_q);
                end else if (!fits) begin
                    done_q   <= 1'b1;
                    result_q <= '0;
                    err_q    <= 1'b1;
                end
            end
            if (state_q == S_PAYLD) begin
                pidx_q <= pidx_q + 1'b1;
                if (last_pay) begin
                    done_q   <= 1'b1;
                    result_q <= '0;
                end
            end
        end
    end

    assign busy    = (state_q != S_IDLE);
    assign done    = done_q;
    assign result  = result_q;
    assign pay_err = err_q;

endmodule

// File: rtl/xks_seq_chk.sv
module xks_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       pay_err,
    input logic       mem_we,
    input logic       alu_req,
    input logic [7:0] alu_a,
    input logic [7:0] alu_b,
    input logic       alu_ack
);

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10
    alu_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_req && !alu_ack) |=> (alu_req && $stable(alu_a) && $stable(alu_b)));

    // R8
    we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R6
    err_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pay_err) |-> done);

endmodule

bind xks_seq xks_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .pay_err (pay_err),
    .mem_we  (mem_we),
    .alu_req (alu_req),
    .alu_a   (alu_a),
    .alu_b   (alu_b),
    .alu_ack (alu_ack)
);

// File: tb/xks_seq_tb.sv
`timescale 1ns/1ps
module xks_seq_tb;

    localparam int          MEMB = 4096;
    localparam logic [79:0] KEY  = 80'h9C5E21B704F368AD12E5;
    localparam logic [31:0] PAY  = 32'h7A19C45B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_verify = 1'b0;
    logic [11:0] cmd_ptr = '0;
    logic        busy, done, pay_err, mem_we, alu_req, alu_ack;
    logic [7:0]  result, mem_wdata, mem_rdata, alu_a, alu_b, alu_y;
    logic [11:0] mem_addr;

    logic [7:0]  mem [0:MEMB-1];
    logic [15:0] hitmask = 16'hFFFF;
    logic        waited;
    logic [4:0]  xcount;
    logic        xclr = 1'b0;

    int checks = 0, errors = 0;
    logic [8:0] sb_q[$];

    always #2.5 clk = ~clk;

    xks_seq #(.KEY(KEY), .PAYLOAD(PAY)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_verify(cmd_verify),
        .cmd_ptr(cmd_ptr), .busy(busy), .done(done), .result(result), .pay_err(pay_err),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .alu_req(alu_req), .alu_a(alu_a), .alu_b(alu_b), .alu_ack(alu_ack), .alu_y(alu_y)
    );

    // memory model
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
    assign mem_rdata = mem[mem_addr];

    // ALU model: per-request hit mask, a miss answers one cycle later
    assign alu_ack = alu_req && (hitmask[xcount[3:0]] || waited);
    assign alu_y   = alu_a ^ alu_b;
    always @(posedge clk) begin
        if (!rst_n) begin
            waited <= 1'b0;
            xcount <= '0;
        end else begin
            waited <= alu_req && !alu_ack;
            if (xclr)                     xcount <= '0;
            else if (alu_req && alu_ack)  xcount <= xcount + 1'b1;
        end
    end

    function automatic logic [7:0] kb(int k);
        return KEY[8*k +: 8];
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: pops the expected completion and compares
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check("R8", "unexpected completion", 1, 0);
            end else begin
                logic [8:0] e;
                e = sb_q.pop_front();
                check("R3/R4", "result", int'(result), int'(e[7:0]));
                check("R6", "pay_err", int'(pay_err), int'(e[8]));
            end
        end
    end

    // driver: pushes the expected completion, runs one command
    task automatic run(logic op, logic [11:0] ptr, logic [15:0] mask,
                       logic [7:0] exp_res, logic exp_err, bit probe);
        int nbusy;
        @(negedge clk);
        hitmask = mask;
        xclr    = 1'b1;
        @(negedge clk);
        xclr       = 1'b0;
        cmd_valid  = 1'b1;
        cmd_verify = op;
        cmd_ptr    = ptr;
        sb_q.push_back({exp_err, exp_res});
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R7", "busy after accept", int'(busy), 1);
        nbusy = 1;
        if (probe) begin
            cmd_valid  = 1'b1;
            cmd_verify = 1'b1;
            cmd_ptr    = 12'h600;
        end
        do begin
            @(negedge clk);
            if (nbusy >= 4) cmd_valid = 1'b0;
            if (busy) nbusy++;
        end while (!done);
        cmd_valid = 1'b0;
        if (!op) check("R3", "busy cycle count", nbusy, int'(exp_res));
        repeat (3) @(negedge clk);
        check("R7", "idle after done", int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("R7", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] snap [0:15];
        logic [7:0] acc;
        for (int i = 0; i < MEMB; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 4));
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "result in reset", int'(result), 0);
        check("R1", "pay_err in reset", int'(pay_err), 0);
        check("R1", "mem_we in reset", int'(mem_we), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 encrypt, all ALU hits: 30 cycles
        for (int k = 0; k < 12; k++) snap[k] = mem[12'h0FF + k];
        run(1'b0, 12'h100, 16'hFFFF, 8'd30, 1'b0, 1'b0);
        for (int k = 0; k < 10; k++)
            check("R2", "encrypted byte", int'(mem[12'h100 + k]), int'(snap[k+1] ^ kb(k)));
        check("R2", "byte below window", int'(mem[12'h0FF]), int'(snap[0]));
        check("R2", "byte above window", int'(mem[12'h10A]), int'(snap[11]));

        // R3 / R10 all misses: 40 cycles, data still correct
        for (int k = 0; k < 10; k++) snap[k] = mem[12'h200 + k];
        run(1'b0, 12'h200, 16'h0000, 8'd40, 1'b0, 1'b0);
        for (int k = 0; k < 10; k++)
            check("R10", "encrypted byte with slow ALU", int'(mem[12'h200 + k]), int'(snap[k] ^ kb(k)));

        // R3 mixed: five hits, five misses: 35 cycles
        run(1'b0, 12'h280, 16'h0155, 8'd35, 1'b0, 1'b0);

        // R9 window wraps at end of memory
        for (int k = 0; k < 10; k++) snap[k] = mem[12'(12'hFFB + k)];
        run(1'b0, 12'hFFB, 16'hFFFF, 8'd30, 1'b0, 1'b0);
        for (int k = 0; k < 10; k++)
            check("R9", "wrapped byte", int'(mem[12'(12'hFFB + k)]), int'(snap[k] ^ kb(k)));

        // R4 verify mismatch
        acc = 8'h00;
        for (int k = 0; k < 10; k++) acc = acc | (mem[12'h300 + k] ^ kb(k));
        for (int k = 0; k < 4; k++) snap[k] = mem[12'h30A + k];
        run(1'b1, 12'h300, 16'h0155, acc, 1'b0, 1'b0);
        for (int k = 0; k < 4; k++)
            check("R4", "no payload on mismatch", int'(mem[12'h30A + k]), int'(snap[k]));

        // R5 verify match writes payload
        for (int k = 0; k < 10; k++) mem[12'h400 + k] = kb(k);
        run(1'b1, 12'h400, 16'h0155, 8'h00, 1'b0, 1'b0);
        for (int j = 0; j < 4; j++)
            check("R5", "payload byte", int'(mem[12'h40A + j]), int'(PAY[8*j +: 8]));

        // R6 exact fit at 0xFF2
        for (int k = 0; k < 10; k++) mem[12'hFF2 + k] = kb(k);
        run(1'b1, 12'hFF2, 16'hFFFF, 8'h00, 1'b0, 1'b0);
        for (int j = 0; j < 4; j++)
            check("R6", "payload at memory top", int'(mem[12'hFFC + j]), int'(PAY[8*j +: 8]));

        // R6 one byte over at 0xFF3
        for (int k = 0; k < 10; k++) mem[12'hFF3 + k] = kb(k);
        mem[12'hFFD] = 8'h11; mem[12'hFFE] = 8'h22; mem[12'hFFF] = 8'h33;
        run(1'b1, 12'hFF3, 16'hFFFF, 8'h00, 1'b1, 1'b0);
        check("R6", "no write past end FFD", int'(mem[12'hFFD]), 8'h11);
        check("R6", "no write past end FFF", int'(mem[12'hFFF]), 8'h33);
        check("R6", "error flag held", int'(pay_err), 1);

        // R8 verify command during encrypt is ignored
        for (int k = 0; k < 10; k++) mem[12'h600 + k] = kb(k);
        mem[12'h60A] = 8'hA5;
        run(1'b0, 12'h500, 16'hFFFF, 8'd30, 1'b0, 1'b1);
        check("R8", "ignored verify wrote nothing", int'(mem[12'h60A]), 8'hA5);
        check("R8", "no pending completion", sb_q.size(), 0);
        check("R8", "pay_err clear", int'(pay_err), 0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule